// File: doc/BRIEF.md
# Mesh Vertex Iteration Sequencer

This block drives a microcoded vertex engine over a two-dimensional grid of points. Software programs a base address and the last column and row indices through a small register port, then sets the start bit. The sequencer walks every grid point in row-major order. For each point it pulses a launch strobe that tells the engine to load the column index into general register 0 and the row index into general register 1, and to restart its program at address zero. It then counts the instructions the engine retires while waiting for the engine's vector-output instruction.

When that instruction retires, the sequencer captures its two operand words. It then issues them as two write requests to a fixed-stride output address, where every row spans 128 points of 8 bytes each. It waits for memory to accept both words before moving on. A point whose program retires the instruction limit without a vector-output is abandoned, and the walk continues with the next point.

After the last point the block stores the total number of grid points, clears its busy flag and raises a one-cycle interrupt. The arithmetic engine and the memory system sit outside this block. The engine is represented by a retire strobe with operands, and memory by a request/acknowledge pair.

Top module: `mesh_seq`

## Requirements
- R1: Writing register address 0 with bit 0 set while the block is idle starts a run whose first launch carries column 0 and row 0. Bit 0 of a read at address 0 returns 1 for the whole run.
- R2: Launches (`pt_go`, one cycle each) visit columns 0 up to the last-column register (address 2) in the inner loop and rows 0 up to the last-row register (address 3) in the outer loop, with both limits inclusive. `pt_x` and `pt_y` carry the point's coordinates.
- R3: The output of a point is written in two beats. The first beat writes the A operand to base + 8 × (128 × row + column), modulo 2^32, using the base register at address 1. The second beat writes the B operand to that address plus 4.
- R4: `mem_addr` and `mem_data` stay stable while `mem_req` is high and `mem_ack` is low. No launch occurs until the second beat has been acknowledged.
- R5: The register at address 5 holds the second-beat address of the most recent point whose output was fully written.
- R6: At the end of a run, the register at address 4 reads (last column + 1) × (last row + 1).
- R7: `irq` is high for exactly one cycle at the end of a run, and in that cycle bit 0 of address 0 reads 0.
- R8: If `INSN_LIMIT` instructions retire for one point without a vector-output, the point produces no write request and the next point is launched. A vector-output retiring as instruction number `INSN_LIMIT` is still written out.
- R9: While a run is in progress, start requests and writes to addresses 1 to 3 are ignored. The run keeps its order, its addresses and its final count.
- R10: After reset, addresses 0 to 5 read 0, and `irq`, `mem_req` and `pt_go` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address: 0 control, 1 base, 2 last column, 3 last row, 4 point count, 5 last output address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| pt_go | output | 1 | Launch pulse: load coordinates into registers 0/1, restart program at 0 |
| pt_x | output | COORD_W | Column of the launched point |
| pt_y | output | COORD_W | Row of the launched point |
| eng_step | input | 1 | Engine retired one instruction |
| eng_vout | input | 1 | The retired instruction is the vector-output |
| eng_opa | input | 32 | A operand of the vector-output |
| eng_opb | input | 32 | B operand of the vector-output |
| mem_req | output | 1 | Write request |
| mem_addr | output | 32 | Write byte address |
| mem_data | output | 32 | Write data |
| mem_ack | input | 1 | Memory accepted the current beat |
| irq | output | 1 | End-of-run pulse |

## Verification
The hardest situation to reach from the ports is the instruction-limit abort, together with its boundary twin: a vector-output that retires exactly as the limit is reached. The bench acts as the engine. In one point it retires 2048 plain instructions and checks that no write request appears and the next launch follows. In the next point it retires 2047 plain instructions and then a vector-output, and checks that the output is written. Interference during a run is reached by issuing start and configuration writes between a launch and the point's first retired instruction.

// File: rtl/mesh_seq_pkg.sv
package mesh_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LAUNCH,
    S_RUN,
    S_WR_A,
    S_WR_B,
    S_STEP,
    S_DONE
  } seq_state_t;

  localparam logic [2:0] REG_CTRL  = 3'd0;
  localparam logic [2:0] REG_BASE  = 3'd1;
  localparam logic [2:0] REG_HLAST = 3'd2;
  localparam logic [2:0] REG_VLAST = 3'd3;
  localparam logic [2:0] REG_COUNT = 3'd4;
  localparam logic [2:0] REG_LAST  = 3'd5;

  // Output address of a grid point: 8 bytes per point, fixed row pitch.
  function automatic logic [31:0] mesh_dma_addr(input logic [31:0] base,
                                                input logic [31:0] col,
                                                input logic [31:0] row,
                                                input int unsigned pitch);
    logic [31:0] idx;
    idx = row * pitch + col;
    return base + {idx[28:0], 3'b000};
  endfunction

  // Number of points visited by a run with inclusive last indices.
  function automatic logic [31:0] mesh_point_total(input logic [31:0] hl,
                                                   input logic [31:0] vl);
    return (hl + 32'd1) * (vl + 32'd1);
  endfunction

endpackage

// File: rtl/mesh_seq_cfg.sv
module mesh_seq_cfg
  import mesh_seq_pkg::*;
#(
  parameter int COORD_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [2:0]         addr,
  input  logic [31:0]        wdata,
  output logic [31:0]        rdata,
  input  logic               busy,
  input  logic               set_count,
  input  logic [31:0]        count_val,
  input  logic               set_last,
  input  logic [31:0]        last_val,
  output logic [31:0]        base,
  output logic [COORD_W-1:0] hlast,
  output logic [COORD_W-1:0] vlast
);

  logic [31:0] count_q;
  logic [31:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base    <= '0;
      hlast   <= '0;
      vlast   <= '0;
      count_q <= '0;
      last_q  <= '0;
    end else begin
      if (we && !busy) begin
        case (addr)
          REG_BASE:  base  <= wdata;
          REG_HLAST: hlast <= wdata[COORD_W-1:0];
          REG_VLAST: vlast <= wdata[COORD_W-1:0];
          default:   ;
        endcase
      end
      if (set_count) count_q <= count_val;
      if (set_last)  last_q  <= last_val;
    end
  end

  always_comb begin
    case (addr)
      REG_CTRL:  rdata = {31'd0, busy};
      REG_BASE:  rdata = base;
      REG_HLAST: rdata = 32'(hlast);
      REG_VLAST: rdata = 32'(vlast);
      REG_COUNT: rdata = count_q;
      REG_LAST:  rdata = last_q;
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/mesh_seq_walk.sv
module mesh_seq_walk #(
  parameter int COORD_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               adv,
  input  logic [COORD_W-1:0] hlast,
  input  logic [COORD_W-1:0] vlast,
  output logic [COORD_W-1:0] col,
  output logic [COORD_W-1:0] row,
  output logic               last
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else if (clr) begin
      col <= '0;
      row <= '0;
    end else if (adv) begin
      if (col == hlast) begin
        col <= '0;
        row <= row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  assign last = (col == hlast) && (row == vlast);

endmodule

// File: rtl/mesh_seq_guard.sv
module mesh_seq_guard #(
  parameter int LIMIT = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic hit
);

  localparam int CW = (LIMIT > 2) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (clr)  cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end

  // The step arriving while hit is high is number LIMIT for this point.
  assign hit = (cnt == CW'(LIMIT - 1));

endmodule

// File: rtl/mesh_seq.sv
module mesh_seq
  import mesh_seq_pkg::*;
#(
  parameter int          COORD_W    = 7,
  parameter int unsigned PITCH      = 128,
  parameter int          INSN_LIMIT = 2048
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               pt_go,
  output logic [COORD_W-1:0] pt_x,
  output logic [COORD_W-1:0] pt_y,
  input  logic               eng_step,
  input  logic               eng_vout,
  input  logic [31:0]        eng_opa,
  input  logic [31:0]        eng_opb,
  output logic               mem_req,
  output logic [31:0]        mem_addr,
  output logic [31:0]        mem_data,
  input  logic               mem_ack,
  output logic               irq
);

  seq_state_t state;
  logic [31:0] opa_q, opb_q;

  logic [31:0]        cfg_base;
  logic [COORD_W-1:0] cfg_hlast, cfg_vlast;
  logic [COORD_W-1:0] walk_col, walk_row;
  logic               walk_last;
  logic               guard_hit;
  logic [31:0]        cur_addr;

  // Named internal events, also watched by the checker.
  logic busy;
  logic start_req;
  logic start_accept;
  logic ev_vout;
  logic ev_abort;
  logic wr_second;

  assign busy         = (state != S_IDLE) && (state != S_DONE);
  assign start_req    = reg_we && (reg_addr == REG_CTRL) && reg_wdata[0];
  assign start_accept = start_req && !busy;
  assign ev_vout      = (state == S_RUN) && eng_step && eng_vout;
  assign ev_abort     = (state == S_RUN) && eng_step && !eng_vout && guard_hit;
  assign wr_second    = (state == S_WR_B);

  assign cur_addr = mesh_dma_addr(cfg_base, 32'(walk_col), 32'(walk_row), PITCH);

  mesh_seq_cfg #(.COORD_W(COORD_W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (reg_we),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .busy      (busy),
    .set_count ((state == S_STEP) && walk_last),
    .count_val (mesh_point_total(32'(cfg_hlast), 32'(cfg_vlast))),
    .set_last  (wr_second && mem_ack),
    .last_val  (cur_addr + 32'd4),
    .base      (cfg_base),
    .hlast     (cfg_hlast),
    .vlast     (cfg_vlast)
  );

  mesh_seq_walk #(.COORD_W(COORD_W)) u_walk (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (start_accept),
    .adv   ((state == S_STEP) && !walk_last),
    .hlast (cfg_hlast),
    .vlast (cfg_vlast),
    .col   (walk_col),
    .row   (walk_row),
    .last  (walk_last)
  );

  mesh_seq_guard #(.LIMIT(INSN_LIMIT)) u_guard (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state == S_LAUNCH),
    .step  ((state == S_RUN) && eng_step && !eng_vout),
    .hit   (guard_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      opa_q <= '0;
      opb_q <= '0;
    end else begin
      case (state)
        S_IDLE, S_DONE: state <= start_accept ? S_LAUNCH : S_IDLE;
        S_LAUNCH:       state <= S_RUN;
        S_RUN: begin
          if (ev_vout) begin
            opa_q <= eng_opa;
            opb_q <= eng_opb;
            state <= S_WR_A;
          end else if (ev_abort) begin
            state <= S_STEP;
          end
        end
        S_WR_A:  if (mem_ack) state <= S_WR_B;
        S_WR_B:  if (mem_ack) state <= S_STEP;
        S_STEP:  state <= walk_last ? S_DONE : S_LAUNCH;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign pt_go    = (state == S_LAUNCH);
  assign pt_x     = walk_col;
  assign pt_y     = walk_row;
  assign mem_req  = (state == S_WR_A) || wr_second;
  assign mem_addr = wr_second ? cur_addr + 32'd4 : cur_addr;
  assign mem_data = wr_second ? opb_q : opa_q;
  assign irq      = (state == S_DONE);

endmodule

// File: rtl/mesh_seq_chk.sv
module mesh_seq_chk #(
  parameter int COORD_W = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               irq,
  input logic               busy,
  input logic               pt_go,
  input logic [COORD_W-1:0] pt_x,
  input logic [COORD_W-1:0] pt_y,
  input logic               mem_req,
  input logic               mem_ack,
  input logic [31:0]        mem_addr,
  input logic [31:0]        mem_data,
  input logic               wr_second,
  input logic               start_accept,
  input logic               ev_abort
);

  p_first_point_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start_accept |=> pt_go && (pt_x == '0) && (pt_y == '0));

  p_go_in_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pt_go |-> busy);

  p_second_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && !wr_second) |=>
      (mem_req && wr_second && (mem_addr == $past(mem_addr) + 32'd4)));

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));

  p_no_go_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !pt_go);

  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_irq_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);

  p_abort_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> !mem_req);

endmodule

bind mesh_seq mesh_seq_chk #(.COORD_W(COORD_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .irq          (irq),
  .busy         (busy),
  .pt_go        (pt_go),
  .pt_x         (pt_x),
  .pt_y         (pt_y),
  .mem_req      (mem_req),
  .mem_ack      (mem_ack),
  .mem_addr     (mem_addr),
  .mem_data     (mem_data),
  .wr_second    (wr_second),
  .start_accept (start_accept),
  .ev_abort     (ev_abort)
);

// File: tb/mesh_seq_test.sv
`timescale 1ns/1ps
module mesh_seq_test;

  localparam int CW    = 7;
  localparam int LIMIT = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pt_go;
  logic [CW-1:0] pt_x, pt_y;
  logic        eng_step = 1'b0, eng_vout = 1'b0;
  logic [31:0] eng_opa = '0, eng_opb = '0;
  logic        mem_req;
  logic [31:0] mem_addr, mem_data;
  logic        mem_ack = 1'b0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_last = '0;

  always #4 clk = ~clk;

  mesh_seq uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pt_go(pt_go),
    .pt_x(pt_x), .pt_y(pt_y), .eng_step(eng_step), .eng_vout(eng_vout),
    .eng_opa(eng_opa), .eng_opb(eng_opb), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_ack(mem_ack), .irq(irq)
  );

  // base[47:16], last column [15:8], last row [7:0]
  localparam logic [47:0] RUNS [4] = '{
    {32'h0000_1000, 8'd1,   8'd1},
    {32'h8000_0000, 8'd2,   8'd0},
    {32'hFFFF_FFC0, 8'd0,   8'd2},
    {32'h0002_0000, 8'd127, 8'd1}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr(input logic [31:0] base, input int x, input int y);
    return base + 32'(y * 1024) + 32'(x * 8);
  endfunction

  function automatic logic [31:0] pat_a(input int x, input int y);
    return 32'hA500_0000 ^ 32'((y << 8) | x);
  endfunction

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 3'd0; reg_wdata = '0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
    reg_addr = 3'd0;
  endtask

  task automatic wait_go();
    int n = 0;
    while (!pt_go && n < 100) begin @(negedge clk); n++; end
  endtask

  task automatic wait_req();
    int n = 0;
    while (!mem_req && n < 100) begin @(negedge clk); n++; end
  endtask

  task automatic do_point(input int ex, input int ey, input logic [31:0] base,
                          input int nsteps, input bit vout, input int ackdly,
                          input bit meddle, input bit first);
    logic [31:0] a, rd;
    wait_go();
    chk(pt_go == 1'b1, "R2", "launch seen", 32'(pt_go), 32'd1);
    chk(pt_x == CW'(ex) && pt_y == CW'(ey), "R2", "launch coords",
        32'({pt_y, pt_x}), 32'({CW'(ey), CW'(ex)}));
    if (first) chk(reg_rdata[0] == 1'b1, "R1", "busy during run", 32'(reg_rdata[0]), 32'd1);
    if (meddle) begin
      reg_write(3'd0, 32'd1);
      reg_write(3'd1, 32'hDEAD_0000);
      reg_write(3'd2, 32'd5);
      chk(pt_go == 1'b0, "R9", "no relaunch on start while busy", 32'(pt_go), 32'd0);
      reg_read(3'd1, rd);
      chk(rd == base, "R9", "base unchanged while busy", rd, base);
    end
    @(negedge clk);
    a = pat_a(ex, ey);
    for (int i = 0; i < nsteps; i++) begin
      eng_step = 1'b1;
      eng_vout = vout && (i == nsteps - 1);
      eng_opa  = eng_vout ? a : 32'h0BAD_0BAD;
      eng_opb  = eng_vout ? ~a : 32'h0BAD_0BAD;
      @(negedge clk);
    end
    eng_step = 1'b0; eng_vout = 1'b0;
    if (!vout) begin
      chk(mem_req == 1'b0, "R8", "no write after abort", 32'(mem_req), 32'd0);
      return;
    end
    wait_req();
    chk(mem_req && mem_addr == exp_addr(base, ex, ey), "R3", "first beat addr",
        mem_addr, exp_addr(base, ex, ey));
    chk(mem_data == a, "R3", "first beat data", mem_data, a);
    for (int d = 0; d < ackdly; d++) begin
      @(negedge clk);
      chk(mem_req && mem_addr == exp_addr(base, ex, ey) && !pt_go, "R4",
          "hold while not acked", mem_addr, exp_addr(base, ex, ey));
    end
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    chk(mem_req && mem_addr == exp_addr(base, ex, ey) + 32'd4, "R3", "second beat addr",
        mem_addr, exp_addr(base, ex, ey) + 32'd4);
    chk(mem_data == ~a, "R3", "second beat data", mem_data, ~a);
    mem_ack = 1'b1;
    @(negedge clk);
    mem_ack = 1'b0;
    chk(!mem_req && !pt_go, "R4", "idle gap after second beat", 32'({mem_req, pt_go}), 32'd0);
    exp_last = exp_addr(base, ex, ey) + 32'd4;
  endtask

  task automatic finish_run(input int h, input int v);
    logic [31:0] rd;
    int n = 0;
    while (!irq && n < 100) begin @(negedge clk); n++; end
    chk(irq == 1'b1, "R7", "irq raised", 32'(irq), 32'd1);
    chk(reg_rdata[0] == 1'b0, "R7", "busy low with irq", 32'(reg_rdata[0]), 32'd0);
    @(negedge clk);
    chk(irq == 1'b0, "R7", "irq one cycle", 32'(irq), 32'd0);
    reg_read(3'd4, rd);
    chk(rd == 32'((h + 1) * (v + 1)), "R6", "point count", rd, 32'((h + 1) * (v + 1)));
    reg_read(3'd5, rd);
    chk(rd == exp_last, "R5", "last output address", rd, exp_last);
  endtask

  task automatic run_mesh(input logic [31:0] base, input int h, input int v,
                          input bit abort_mode, input bit meddle);
    reg_write(3'd1, base);
    reg_write(3'd2, 32'(h));
    reg_write(3'd3, 32'(v));
    reg_write(3'd0, 32'd1);
    for (int y = 0; y <= v; y++)
      for (int x = 0; x <= h; x++) begin
        if (abort_mode)
          do_point(x, y, base, LIMIT, !(x == 0 && y == 0), 0, 1'b0, x == 0 && y == 0);
        else
          do_point(x, y, base, ((x + y) % 3) + 1, 1'b1, x % 2,
                   meddle && x == 0 && y == 0, x == 0 && y == 0);
      end
    finish_run(h, v);
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(!irq && !mem_req && !pt_go, "R10", "outputs after reset",
        32'({irq, mem_req, pt_go}), 32'd0);
    for (int a = 0; a < 6; a++) begin
      reg_read(3'(a), rd);
      chk(rd == 32'd0, "R10", "register after reset", rd, 32'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1, R2, R3, R4, R5, R6, R7: table of meshes
    foreach (RUNS[i])
      run_mesh(RUNS[i][47:16], int'(RUNS[i][15:8]), int'(RUNS[i][7:0]), 1'b0, 1'b0);

    // R9: start and config writes during a run are ignored
    run_mesh(32'h0000_4000, 1, 1, 1'b0, 1'b1);

    // R8: first point hits the limit, second emits on the limit step
    run_mesh(32'h0000_8000, 1, 0, 1'b1, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule